// File: doc/BRIEF.md
# Load-Dependent Conduction Mode Controller

This block picks the operating mode of a synchronous buck converter from a filtered load-current code. It steps through four modes as the load falls: fixed-frequency continuous conduction, discontinuous conduction with the synchronous rectifier active, discontinuous conduction with the rectifier idle, and variable-frequency pulse skipping. As the load rises it steps back the same way. Each boundary has its own lower (step-down) and upper (step-up) threshold. The gap between the two is a hysteresis band in which the mode holds, so the mode cannot chatter.

Decisions are made only on a switching-period strobe, and each strobe moves the mode by at most one step. At the same strobe the block sets the rectifier enable. It also computes the rectifier on-time as a linear function of the load code, clipped to programmable bounds. In pulse-skipping mode it decides whether to skip the coming period, using the sign of the output error code. All outputs are registered and held until the next strobe.

Top module: `cond_mode_ctrl`

## Requirements
- R1: When reset is asserted, the outputs take these values: `mode` = 0 (continuous), `sr_en` = 1, `skip` = 0 and `sr_ton` = 0. Reset is synchronous and active high.
- R2: The outputs change only at a clock edge where `period_stb` is high. The new values are visible after that edge and stay unchanged while the strobe is low, whatever the other inputs do.
- R3: The mode codes are 0 = continuous, 1 = discontinuous with rectifier, 2 = discontinuous without rectifier, 3 = pulse skipping. At a strobe, the mode steps down as follows: 0 goes to 1 if `load_code < thr_ccm_dn`; 1 goes to 2 if `load_code < thr_sr_dn`; 2 goes to 3 if `load_code < thr_skip_dn`. A load equal to a threshold does not cause a step.
- R4: At a strobe, the mode steps up as follows: 1 goes to 0 if `load_code > thr_ccm_up`; 2 goes to 1 if `load_code > thr_sr_up`; 3 goes to 2 if `load_code > thr_skip_up`. A step up is checked before a step down. In every other case, including loads inside a hysteresis band, the mode holds.
- R5: One strobe changes the mode code by at most one step, even if the load is far past several thresholds.
- R6: `sr_en` is 1 in modes 0 and 1 and 0 in modes 2 and 3.
- R7: `skip` is 1 only when the new mode is 3 and `err_code` is above zero at the strobe. `err_code` is a two's-complement value; a positive value means the output is above the reference. `skip` is 0 for a zero or negative error.
- R8: At each strobe, `sr_ton` is loaded with `ton_offset + ((load_code * ton_gain) >> GSH)`, with GSH = 4 by default. The result is clipped so that it is at least `ton_min` and at most `ton_max`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | One-cycle strobe at each switching-period boundary |
| load_code | input | IW (10) | Filtered load-current code |
| err_code | input | EW (8) | Signed output error; positive means above reference |
| thr_ccm_dn | input | IW | Leave continuous mode below this load |
| thr_ccm_up | input | IW | Return to continuous mode above this load |
| thr_sr_dn | input | IW | Disable the rectifier below this load |
| thr_sr_up | input | IW | Re-enable the rectifier above this load |
| thr_skip_dn | input | IW | Enter pulse skipping below this load |
| thr_skip_up | input | IW | Leave pulse skipping above this load |
| ton_gain | input | GW (8) | On-time slope, scaled down by 2^GSH |
| ton_offset | input | TW (10) | On-time intercept |
| ton_min | input | TW | Lower clip bound for the on-time |
| ton_max | input | TW | Upper clip bound for the on-time |
| mode | output | 2 | Current conduction mode code |
| sr_en | output | 1 | Synchronous rectifier enable |
| sr_ton | output | TW | Scheduled rectifier on-time |
| skip | output | 1 | Skip the current switching period |

## Verification
All four results (mode, rectifier enable, skip flag and on-time) are loaded at the same strobe edge, so each one is due exactly one clock edge after the strobe is seen. The bench raises the strobe on a falling edge and lowers it on the next falling edge. It samples every output on that same falling edge, just after the capturing edge and well before the next rising edge. To show that the outputs hold between strobes, the bench changes the inputs without a strobe over several cycles and checks that the outputs stay as they were.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    MODE_CCM  = 2'd0,
    MODE_DSR  = 2'd1,
    MODE_DNSR = 2'd2,
    MODE_SKIP = 2'd3
  } cmc_mode_t;
endpackage

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
  import cmc_pkg::*;
#(
  parameter int IW = 10,
  parameter int EW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 period_stb,
  input  logic [IW-1:0]        load_code,
  input  logic signed [EW-1:0] err_code,
  input  logic [IW-1:0]        thr_ccm_dn,
  input  logic [IW-1:0]        thr_ccm_up,
  input  logic [IW-1:0]        thr_sr_dn,
  input  logic [IW-1:0]        thr_sr_up,
  input  logic [IW-1:0]        thr_skip_dn,
  input  logic [IW-1:0]        thr_skip_up,
  output cmc_mode_t            mode_q,
  output logic                 sr_en_q,
  output logic                 skip_q
);
  cmc_mode_t mode_nx;
  logic      err_above;

  // A positive error means the output voltage sits above the reference.
  assign err_above = !err_code[EW-1] && (err_code != '0);

  // Step-up is checked before step-down; each strobe moves one step at most.
  always_comb begin
    mode_nx = mode_q;
    unique case (mode_q)
      MODE_CCM:  if (load_code < thr_ccm_dn) mode_nx = MODE_DSR;
      MODE_DSR:  if (load_code > thr_ccm_up) mode_nx = MODE_CCM;
                 else if (load_code < thr_sr_dn) mode_nx = MODE_DNSR;
      MODE_DNSR: if (load_code > thr_sr_up) mode_nx = MODE_DSR;
                 else if (load_code < thr_skip_dn) mode_nx = MODE_SKIP;
      MODE_SKIP: if (load_code > thr_skip_up) mode_nx = MODE_DNSR;
      default:   mode_nx = MODE_CCM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_CCM;
      sr_en_q <= 1'b1;
      skip_q  <= 1'b0;
    end else if (period_stb) begin
      mode_q  <= mode_nx;
      sr_en_q <= (mode_nx == MODE_CCM) || (mode_nx == MODE_DSR);
      skip_q  <= (mode_nx == MODE_SKIP) && err_above;
    end
  end

  assert_hold_mode_R2: assert property (@(posedge clk) disable iff (rst)
    !period_stb |=> ($stable(mode_q) && $stable(skip_q) && $stable(sr_en_q)));

  assert_one_step_R5: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> ((mode_q == $past(mode_q)) ||
                    ({1'b0, mode_q} == {1'b0, $past(mode_q)} + 3'd1) ||
                    ({1'b0, mode_q} + 3'd1 == {1'b0, $past(mode_q)})));

  assert_ccm_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (period_stb && mode_q == MODE_CCM && load_code >= thr_ccm_dn) |=> (mode_q == MODE_CCM));

  assert_skip_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (period_stb && mode_q == MODE_SKIP && load_code > thr_skip_up) |=> (mode_q == MODE_DNSR));
endmodule

// File: rtl/cmc_ton_sched.sv
module cmc_ton_sched #(
  parameter int IW  = 10,
  parameter int GW  = 8,
  parameter int TW  = 10,
  parameter int GSH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          period_stb,
  input  logic [IW-1:0] load_code,
  input  logic [GW-1:0] ton_gain,
  input  logic [TW-1:0] ton_offset,
  input  logic [TW-1:0] ton_min,
  input  logic [TW-1:0] ton_max,
  output logic [TW-1:0] ton_q
);
  localparam int PW = IW + GW;
  localparam int SW = PW + 1;

  logic [PW-1:0] prod;
  logic [SW-1:0] raw, lo_w, hi_w;
  logic [TW-1:0] ton_nx;

  assign prod = {{GW{1'b0}}, load_code} * {{IW{1'b0}}, ton_gain};
  assign raw  = {1'b0, prod >> GSH} + {{(SW-TW){1'b0}}, ton_offset};
  assign lo_w = {{(SW-TW){1'b0}}, ton_min};
  assign hi_w = {{(SW-TW){1'b0}}, ton_max};

  always_comb begin
    if (raw > hi_w)      ton_nx = ton_max;
    else if (raw < lo_w) ton_nx = ton_min;
    else                 ton_nx = raw[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)             ton_q <= '0;
    else if (period_stb) ton_q <= ton_nx;
  end

  assert_ton_bounds_R8: assert property (@(posedge clk) disable iff (rst)
    (period_stb && ton_min <= ton_max) |=> (ton_q >= $past(ton_min) && ton_q <= $past(ton_max)));

  assert_ton_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !period_stb |=> $stable(ton_q));
endmodule

// File: rtl/cond_mode_ctrl.sv
module cond_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int IW  = 10,
  parameter int EW  = 8,
  parameter int GW  = 8,
  parameter int TW  = 10,
  parameter int GSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 period_stb,
  input  logic [IW-1:0]        load_code,
  input  logic signed [EW-1:0] err_code,
  input  logic [IW-1:0]        thr_ccm_dn,
  input  logic [IW-1:0]        thr_ccm_up,
  input  logic [IW-1:0]        thr_sr_dn,
  input  logic [IW-1:0]        thr_sr_up,
  input  logic [IW-1:0]        thr_skip_dn,
  input  logic [IW-1:0]        thr_skip_up,
  input  logic [GW-1:0]        ton_gain,
  input  logic [TW-1:0]        ton_offset,
  input  logic [TW-1:0]        ton_min,
  input  logic [TW-1:0]        ton_max,
  output logic [1:0]           mode,
  output logic                 sr_en,
  output logic [TW-1:0]        sr_ton,
  output logic                 skip
);
  cmc_mode_t mode_r;

  cmc_mode_fsm #(.IW(IW), .EW(EW)) u_fsm (
    .clk(clk), .rst(rst), .period_stb(period_stb),
    .load_code(load_code), .err_code(err_code),
    .thr_ccm_dn(thr_ccm_dn), .thr_ccm_up(thr_ccm_up),
    .thr_sr_dn(thr_sr_dn), .thr_sr_up(thr_sr_up),
    .thr_skip_dn(thr_skip_dn), .thr_skip_up(thr_skip_up),
    .mode_q(mode_r), .sr_en_q(sr_en), .skip_q(skip)
  );

  cmc_ton_sched #(.IW(IW), .GW(GW), .TW(TW), .GSH(GSH)) u_ton (
    .clk(clk), .rst(rst), .period_stb(period_stb),
    .load_code(load_code), .ton_gain(ton_gain), .ton_offset(ton_offset),
    .ton_min(ton_min), .ton_max(ton_max), .ton_q(sr_ton)
  );

  assign mode = mode_r;

  assert_sr_en_mode_R6: assert property (@(posedge clk) disable iff (rst)
    sr_en == (mode == 2'd0 || mode == 2'd1));

  assert_skip_mode_R7: assert property (@(posedge clk) disable iff (rst)
    skip |-> (mode == 2'd3));
endmodule

// File: tb/sim_cond_mode_ctrl.sv
module sim_cond_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic period_stb = 1'b0;
  logic [9:0] load_code = '0;
  logic signed [7:0] err_code = '0;
  logic [9:0] thr_ccm_dn = 10'd400, thr_ccm_up = 10'd450;
  logic [9:0] thr_sr_dn = 10'd200, thr_sr_up = 10'd250;
  logic [9:0] thr_skip_dn = 10'd60, thr_skip_up = 10'd90;
  logic [7:0] ton_gain = 8'd16;
  logic [9:0] ton_offset = 10'd20, ton_min = 10'd30, ton_max = 10'd200;
  logic [1:0] mode;
  logic sr_en, skip;
  logic [9:0] sr_ton;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {load, err, mode, sr_en, skip, ton}; ton = 20 + load, clipped to [30,200]
  localparam logic [31:0] VEC [NV] = '{
    {10'd500, 8'h00, 2'd0, 1'b1, 1'b0, 10'd200},
    {10'd420, 8'h00, 2'd0, 1'b1, 1'b0, 10'd200},
    {10'd100, 8'h00, 2'd1, 1'b1, 1'b0, 10'd120},
    {10'd100, 8'h00, 2'd2, 1'b0, 1'b0, 10'd120},
    {10'd100, 8'h00, 2'd2, 1'b0, 1'b0, 10'd120},
    {10'd40,  8'h05, 2'd3, 1'b0, 1'b1, 10'd60},
    {10'd40,  8'hFD, 2'd3, 1'b0, 1'b0, 10'd60},
    {10'd80,  8'h05, 2'd3, 1'b0, 1'b1, 10'd100},
    {10'd95,  8'h05, 2'd2, 1'b0, 1'b0, 10'd115},
    {10'd240, 8'h00, 2'd2, 1'b0, 1'b0, 10'd200},
    {10'd300, 8'h00, 2'd1, 1'b1, 1'b0, 10'd200},
    {10'd430, 8'h00, 2'd1, 1'b1, 1'b0, 10'd200},
    {10'd460, 8'h00, 2'd0, 1'b1, 1'b0, 10'd200},
    {10'd5,   8'h00, 2'd1, 1'b1, 1'b0, 10'd30},
    {10'd5,   8'h00, 2'd2, 1'b0, 1'b0, 10'd30},
    {10'd5,   8'h00, 2'd3, 1'b0, 1'b0, 10'd30},
    {10'd5,   8'h01, 2'd3, 1'b0, 1'b1, 10'd30},
    {10'd60,  8'h01, 2'd3, 1'b0, 1'b1, 10'd80},
    {10'd90,  8'h01, 2'd3, 1'b0, 1'b1, 10'd110},
    {10'd400, 8'h00, 2'd2, 1'b0, 1'b0, 10'd200},
    {10'd200, 8'h00, 2'd2, 1'b0, 1'b0, 10'd200}
  };

  cond_mode_ctrl u0 (
    .clk(clk), .rst(rst), .period_stb(period_stb),
    .load_code(load_code), .err_code(err_code),
    .thr_ccm_dn(thr_ccm_dn), .thr_ccm_up(thr_ccm_up),
    .thr_sr_dn(thr_sr_dn), .thr_sr_up(thr_sr_up),
    .thr_skip_dn(thr_skip_dn), .thr_skip_up(thr_skip_up),
    .ton_gain(ton_gain), .ton_offset(ton_offset),
    .ton_min(ton_min), .ton_max(ton_max),
    .mode(mode), .sr_en(sr_en), .sr_ton(sr_ton), .skip(skip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic strobe(input logic [9:0] ld, input logic [7:0] er);
    @(negedge clk);
    load_code = ld;
    err_code = er;
    period_stb = 1'b1;
    @(negedge clk);
    period_stb = 1'b0;
  endtask

  task automatic chk_all(input string tag, input int m, input int se, input int sk, input int t);
    chk({tag, " mode"}, mode, m);
    chk({tag, " sr_en"}, sr_en, se);
    chk({tag, " skip"}, skip, sk);
    chk({tag, " sr_ton"}, sr_ton, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_all("R1 reset", 0, 1, 0, 0);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][31:22], VEC[i][21:14]);
      chk_all($sformatf("R3 R4 R5 R6 R7 R8 vec%0d", i),
              VEC[i][13:12], VEC[i][11], VEC[i][10], VEC[i][9:0]);
    end

    // R2: no strobe, inputs move far; outputs hold
    @(negedge clk);
    load_code = 10'd10;
    err_code = 8'h10;
    repeat (5) @(negedge clk);
    load_code = 10'd900;
    repeat (3) @(negedge clk);
    chk_all("R2 hold", 2, 0, 0, 200);

    // R8 gain change: 20 + (50*32)>>4 = 120; R3 50 < 60 enters skip
    ton_gain = 8'd32;
    strobe(10'd50, 8'h00);
    chk_all("R8 gain", 3, 0, 0, 120);

    // R5: huge load from skip climbs one step only
    strobe(10'd1000, 8'h00);
    chk("R5 single step mode", mode, 2);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_all("R1 mid reset", 0, 1, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule